// File: doc/BRIEF.md
# Index Register Memory Sequencer

This unit owns the 16-bit index register of a small byte-oriented interpreter core and carries out the operations that move bytes between the general register file and memory through that index. It can load the index from an immediate value or add a register to it. It can point the index at a compact or a wide font glyph. It can split a register into three decimal digits and write them out. It can copy a run of registers v0..vX to or from memory, based either at the index or at address zero.

A command is a one-cycle `start` pulse with an opcode, a register number X, an immediate and a quirk bit. The unit reads registers through a combinational read port and writes them through a write strobe. It reaches memory one byte at a time over a request/acknowledge handshake. `busy` is high while a command runs, and a one-cycle `done` marks its end. All index arithmetic wraps modulo 2^16. Decimal digits come from repeated subtraction of 100 and then 10, so a conversion takes at most eleven cycles before its three writes begin.

Top module: `idxseq_top`

## Requirements
- R1: After reset `indexOut` is 0 and `busy`, `done`, `memReq` and `rfWe` are all 0.
- R2: `opSel` codes: 0 load index, 1 add register, 2 compact glyph, 3 wide glyph, 4 decimal split, 5 block store, 6 block load, 7 flag save, 8 flag restore. Code 0 sets the index to `immIdx`.
- R3: Code 1 adds the unsigned 8-bit value of vX to the index, wrapping modulo 2^16.
- R4: Code 2 sets the index to FONT_BASE + 5*(vX mod 16).
- R5: Code 3 sets the index to FONT_BASE + 40 + 16*(vX mod 16).
- R6: Code 4 writes floor(vX/100) to address I, the tens digit to I+1 and the ones digit to I+2, with addresses wrapping modulo 2^16. The index is left unchanged.
- R7: Code 5 writes v0..vX inclusive to addresses I..I+X. When `quirkKeep` is 0, the index then becomes I+X+1.
- R8: Code 6 loads v0..vX from addresses I..I+X. When `quirkKeep` is 0, the index then becomes I+X+1.
- R9: With `quirkKeep` = 1, codes 5 and 6 move the same bytes but leave the index unchanged.
- R10: Codes 7 and 8 move v0..vX to or from addresses 0..X. The index is neither used nor changed.
- R11: `memReq` stays high, with `memAddr` and `memWe` stable, until `memAck`. Each acknowledged cycle moves exactly one byte.
- R12: `done` is a one-cycle pulse for each accepted command. A `start` that arrives while `busy` is ignored.
- R13: Codes 0 to 3 raise `done`, with the new index visible, two clock cycles after the cycle in which `start` was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, taken only when idle |
| opSel | input | 4 | Command code |
| regIdx | input | 4 | Register number X |
| immIdx | input | 16 | Immediate for index load |
| quirkKeep | input | 1 | Keep the index after block store/load |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| indexOut | output | 16 | Current index register |
| rfAddr | output | 4 | Register file address |
| rfRdData | input | 8 | Register file read data (combinational) |
| rfWe | output | 1 | Register file write strobe |
| rfWrData | output | 8 | Register file write data |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write (1) or read (0) |
| memAddr | output | 16 | Memory byte address |
| memWrData | output | 8 | Memory write data |
| memRdData | input | 8 | Memory read data, valid with memAck |
| memAck | input | 1 | Memory acknowledge |

## Verification
The index-only commands are due exactly two cycles after `start` is sampled. The bench counts falling edges from that sample and expects `done` on the second one. The digit split and block transfers finish after a variable number of cycles, set by the digit count and by a stalling memory model. For these the monitor does not wait a fixed delay. It compares the queued index, memory image and register image on the falling edge where `done` is high. Every request held without acknowledge is checked one cycle later for an unchanged address, and a stray `done` with an empty queue is reported against R12.

// File: rtl/idxseq_pkg.sv
package idxseq_pkg;

  typedef enum logic [3:0] {
    OP_SETI  = 4'd0,
    OP_ADDI  = 4'd1,
    OP_FONTS = 4'd2,
    OP_FONTL = 4'd3,
    OP_BCD   = 4'd4,
    OP_STORE = 4'd5,
    OP_LOAD  = 4'd6,
    OP_FSAVE = 4'd7,
    OP_FLOAD = 4'd8
  } idxOpT;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DIV, ST_DIGIT, ST_XFER, ST_DONE
  } seqStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch X and immediate
    logic setIdx;
    logic addIdx;
    logic fontSmall;
    logic fontLarge;
    logic bcdLoad;
    logic bcdStep;
    logic cntClr;
    logic cntInc;
    logic postInc;    // index += X + 1
    logic selCnt;     // register address from element counter
    logic zeroBase;   // memory base is address 0
    logic digitData;  // memory data is a decimal digit
  } seqStrobeT;

endpackage

// File: rtl/idxseq_ctrl.sv
module idxseq_ctrl
  import idxseq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic [3:0] opSel,
  input  logic      quirkKeep,
  input  logic      memAck,
  input  logic      bcdDone,
  input  logic      cntLast,
  input  logic      cntIsTwo,
  output seqStrobeT stb,
  output logic      memReq,
  output logic      memWe,
  output logic      rfWe,
  output logic      busy,
  output logic      done
);

  seqStateT state, nextState;
  idxOpT    opReg;
  logic     keepReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      opReg   <= OP_SETI;
      keepReg <= 1'b0;
    end else begin
      state <= nextState;
      if (stb.capture) begin
        opReg   <= idxOpT'(opSel);
        keepReg <= quirkKeep;
      end
    end
  end

  logic isFlagOp, isStoreOp;
  assign isFlagOp  = (opReg == OP_FSAVE) || (opReg == OP_FLOAD);
  assign isStoreOp = (opReg == OP_STORE) || (opReg == OP_FSAVE);

  always_comb begin
    nextState = state;
    stb       = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    rfWe      = 1'b0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        stb.capture = 1'b1;
        nextState   = ST_FETCH;
      end
      ST_FETCH: begin
        nextState = ST_DONE;
        case (opReg)
          OP_SETI:  stb.setIdx    = 1'b1;
          OP_ADDI:  stb.addIdx    = 1'b1;
          OP_FONTS: stb.fontSmall = 1'b1;
          OP_FONTL: stb.fontLarge = 1'b1;
          OP_BCD: begin
            stb.bcdLoad = 1'b1;
            nextState   = ST_DIV;
          end
          OP_STORE, OP_LOAD, OP_FSAVE, OP_FLOAD: begin
            stb.cntClr = 1'b1;
            nextState  = ST_XFER;
          end
          default: nextState = ST_DONE;
        endcase
      end
      ST_DIV: begin
        if (bcdDone) begin
          stb.cntClr = 1'b1;
          nextState  = ST_DIGIT;
        end else begin
          stb.bcdStep = 1'b1;
        end
      end
      ST_DIGIT: begin
        memReq        = 1'b1;
        memWe         = 1'b1;
        stb.digitData = 1'b1;
        if (memAck) begin
          if (cntIsTwo) nextState  = ST_DONE;
          else          stb.cntInc = 1'b1;
        end
      end
      ST_XFER: begin
        memReq       = 1'b1;
        memWe        = isStoreOp;
        stb.selCnt   = 1'b1;
        stb.zeroBase = isFlagOp;
        if (memAck) begin
          rfWe = !isStoreOp;
          if (cntLast) begin
            stb.postInc = !isFlagOp && !keepReg;
            nextState   = ST_DONE;
          end else begin
            stb.cntInc = 1'b1;
          end
        end
      end
      ST_DONE: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq);
  p_rf_write_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    rfWe |-> memAck && !memWe);

endmodule

// File: rtl/idxseq_dpath.sv
module idxseq_dpath
  import idxseq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int REG_W     = 4,
  parameter int FONT_BASE = 'h50,
  parameter int WIDE_OFS  = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         stb,
  input  logic [REG_W-1:0]  regIdx,
  input  logic [ADDR_W-1:0] immIdx,
  input  logic [DATA_W-1:0] rfRdData,
  output logic [REG_W-1:0]  rfAddr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic [ADDR_W-1:0] indexOut,
  output logic              bcdDone,
  output logic              cntLast,
  output logic              cntIsTwo
);

  localparam logic [ADDR_W-1:0] SMALL_BASE = ADDR_W'(FONT_BASE);
  localparam logic [ADDR_W-1:0] LARGE_BASE = ADDR_W'(FONT_BASE + WIDE_OFS);

  logic [ADDR_W-1:0] idxReg, immReg;
  logic [REG_W-1:0]  xReg, cnt;
  logic [DATA_W-1:0] workVal;
  logic [3:0]        hund, tens;

  logic [ADDR_W-1:0] glyph, regExt, cntExt;
  assign glyph  = ADDR_W'(rfRdData[3:0]);
  assign regExt = ADDR_W'(rfRdData);
  assign cntExt = ADDR_W'(cnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg  <= '0;
      immReg  <= '0;
      xReg    <= '0;
      cnt     <= '0;
      workVal <= '0;
      hund    <= '0;
      tens    <= '0;
    end else begin
      if (stb.capture) begin
        xReg   <= regIdx;
        immReg <= immIdx;
      end
      if (stb.setIdx)    idxReg <= immReg;
      if (stb.addIdx)    idxReg <= idxReg + regExt;
      if (stb.fontSmall) idxReg <= SMALL_BASE + (glyph << 2) + glyph;
      if (stb.fontLarge) idxReg <= LARGE_BASE + (glyph << 4);
      if (stb.postInc)   idxReg <= idxReg + ADDR_W'(xReg) + ADDR_W'(1);
      if (stb.bcdLoad) begin
        workVal <= rfRdData;
        hund    <= '0;
        tens    <= '0;
      end else if (stb.bcdStep) begin
        if (workVal >= DATA_W'(100)) begin
          workVal <= workVal - DATA_W'(100);
          hund    <= hund + 4'd1;
        end else begin
          workVal <= workVal - DATA_W'(10);
          tens    <= tens + 4'd1;
        end
      end
      if (stb.cntClr)      cnt <= '0;
      else if (stb.cntInc) cnt <= cnt + REG_W'(1);
    end
  end

  assign bcdDone  = (workVal < DATA_W'(10));
  assign cntLast  = (cnt == xReg);
  assign cntIsTwo = (cnt == REG_W'(2));

  assign rfAddr  = stb.selCnt ? cnt : xReg;
  assign memAddr = stb.zeroBase ? cntExt : (idxReg + cntExt);

  always_comb begin
    if (!stb.digitData)        memWrData = rfRdData;
    else if (cnt == REG_W'(0)) memWrData = DATA_W'(hund);
    else if (cnt == REG_W'(1)) memWrData = DATA_W'(tens);
    else                       memWrData = workVal;
  end

  assign indexOut = idxReg;

  p_digit_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.digitData |-> (hund <= 4'd2) && (tens <= 4'd9) && (workVal <= DATA_W'(9)));
  p_step_bounded_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.bcdStep |=> (tens <= 4'd9) && (hund <= 4'd2));

endmodule

// File: rtl/idxseq_top.sv
module idxseq_top
  import idxseq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int REG_CNT   = 16,
  parameter int FONT_BASE = 'h50,
  parameter int WIDE_OFS  = 40,
  localparam int REG_W    = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [3:0]        opSel,
  input  logic [REG_W-1:0]  regIdx,
  input  logic [ADDR_W-1:0] immIdx,
  input  logic              quirkKeep,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] indexOut,
  output logic [REG_W-1:0]  rfAddr,
  input  logic [DATA_W-1:0] rfRdData,
  output logic              rfWe,
  output logic [DATA_W-1:0] rfWrData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              memAck
);

  seqStrobeT stb;
  logic bcdDone, cntLast, cntIsTwo;

  idxseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .quirkKeep(quirkKeep), .memAck(memAck), .bcdDone(bcdDone),
    .cntLast(cntLast), .cntIsTwo(cntIsTwo), .stb(stb),
    .memReq(memReq), .memWe(memWe), .rfWe(rfWe),
    .busy(busy), .done(done)
  );

  idxseq_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W),
    .FONT_BASE(FONT_BASE), .WIDE_OFS(WIDE_OFS)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .regIdx(regIdx), .immIdx(immIdx),
    .rfRdData(rfRdData), .rfAddr(rfAddr), .memAddr(memAddr),
    .memWrData(memWrData), .indexOut(indexOut), .bcdDone(bcdDone),
    .cntLast(cntLast), .cntIsTwo(cntIsTwo)
  );

  assign rfWrData = memRdData;

  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr) && $stable(memWe));
  p_idle_index_r12: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(indexOut));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq && !rfWe && !done);

endmodule

// File: tb/idxseq_top_bench.sv
module idxseq_top_bench;
  import idxseq_pkg::*;

  localparam int FB = 'h50;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  opSel = '0;
  logic [3:0]  regIdx = '0;
  logic [15:0] immIdx = '0;
  logic        quirkKeep = 1'b0;
  logic        busy, done, rfWe, memReq, memWe;
  logic [15:0] indexOut, memAddr;
  logic [3:0]  rfAddr;
  logic [7:0]  rfRdData, rfWrData, memWrData, memRdData;
  logic        memAck;

  always #5 clk = ~clk;

  idxseq_top u_idxseq_top (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .regIdx(regIdx),
    .immIdx(immIdx), .quirkKeep(quirkKeep), .busy(busy), .done(done),
    .indexOut(indexOut), .rfAddr(rfAddr), .rfRdData(rfRdData), .rfWe(rfWe),
    .rfWrData(rfWrData), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWrData(memWrData), .memRdData(memRdData), .memAck(memAck)
  );

  // environment: register file and stalling byte memory
  logic [7:0] regs [16];
  logic [7:0] mem  [65536];
  logic       ackR = 1'b0;
  logic [7:0] stallPat = 8'b1011_0110;
  logic       pokeEn = 1'b0, pokeMem = 1'b0;
  logic [15:0] pokeAddr = '0;
  logic [7:0]  pokeData = '0;

  assign rfRdData  = regs[rfAddr];
  assign memRdData = mem[memAddr];
  assign memAck    = ackR;

  always @(posedge clk) begin
    stallPat <= {stallPat[0], stallPat[7:1]};
    ackR     <= rstN && memReq && !ackR && stallPat[0];
    if (memReq && memAck && memWe) mem[memAddr] <= memWrData;
    if (rfWe) regs[rfAddr] <= rfWrData;
    if (pokeEn) begin
      if (pokeMem) mem[pokeAddr] <= pokeData;
      else         regs[pokeAddr[3:0]] <= pokeData;
    end
  end

  // expected images
  logic [7:0]  expRegs [16];
  logic [7:0]  expMem  [65536];
  logic [15:0] expIdx = '0;

  typedef struct { string tag; logic [15:0] idx; } expT;
  expT expQ [$];

  int nChecks = 0;
  int nFail   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: scoreboard compare on every done
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R12", "done with empty queue", 1, 0);
      end else begin
        expT e;
        int memBad, regBad;
        e = expQ.pop_front();
        memBad = -1;
        regBad = -1;
        for (int a = 0; a < 65536; a++)
          if (memBad < 0 && mem[a] !== expMem[a]) memBad = a;
        for (int r = 0; r < 16; r++)
          if (regBad < 0 && regs[r] !== expRegs[r]) regBad = r;
        check(indexOut == e.idx, e.tag, "index", int'(indexOut), int'(e.idx));
        check(memBad < 0, e.tag, "memory image (first bad addr / value)",
              memBad < 0 ? 0 : int'(mem[memBad]),
              memBad < 0 ? 0 : int'(expMem[memBad]));
        check(regBad < 0, e.tag, "register image (first bad value)",
              regBad < 0 ? 0 : int'(regs[regBad]),
              regBad < 0 ? 0 : int'(expRegs[regBad]));
      end
    end
  end

  // monitor: R11 request must hold with a stable address until acknowledged
  logic        holdPend = 1'b0;
  logic [15:0] holdAddr = '0;
  always @(negedge clk) begin
    if (rstN && holdPend)
      check(memReq && memAddr == holdAddr, "R11", "held request address",
            int'(memAddr), int'(holdAddr));
    holdPend <= rstN && memReq && !memAck;
    holdAddr <= memAddr;
  end

  task automatic poke(input bit isMem, input int a, input logic [7:0] d);
    @(negedge clk);
    pokeEn = 1'b1; pokeMem = isMem; pokeAddr = 16'(a); pokeData = d;
    if (isMem) expMem[a] = d; else expRegs[a] = d;
    @(negedge clk);
    pokeEn = 1'b0;
  endtask

  task automatic runOp(input idxOpT op, input int x, input logic [15:0] imm,
                       input bit keep, input string tag, input bit intrude,
                       output int lat);
    expT e;
    case (op)
      OP_SETI:  expIdx = imm;
      OP_ADDI:  expIdx = expIdx + 16'(expRegs[x]);
      OP_FONTS: expIdx = 16'(FB + 5 * (expRegs[x] % 16));
      OP_FONTL: expIdx = 16'(FB + 40 + 16 * (expRegs[x] % 16));
      OP_BCD: begin
        expMem[16'(expIdx)]      = expRegs[x] / 100;
        expMem[16'(expIdx + 1)]  = (expRegs[x] / 10) % 10;
        expMem[16'(expIdx + 2)]  = expRegs[x] % 10;
      end
      OP_STORE, OP_LOAD: begin
        for (int k = 0; k <= x; k++) begin
          if (op == OP_STORE) expMem[16'(expIdx + k)] = expRegs[k];
          else                expRegs[k] = expMem[16'(expIdx + k)];
        end
        if (!keep) expIdx = expIdx + 16'(x + 1);
      end
      OP_FSAVE: for (int k = 0; k <= x; k++) expMem[k] = expRegs[k];
      OP_FLOAD: for (int k = 0; k <= x; k++) expRegs[k] = expMem[k];
      default: ;
    endcase
    e.tag = tag;
    e.idx = expIdx;
    expQ.push_back(e);
    @(negedge clk);
    opSel = op; regIdx = 4'(x); immIdx = imm; quirkKeep = keep; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (intrude) begin
      start = 1'b1; opSel = OP_SETI; immIdx = 16'hDEAD;
    end
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      start = 1'b0;
    end while (!done);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(indexOut == 16'h0, "R1", "index after reset", int'(indexOut), 0);
    check(!busy && !done, "R1", "busy/done after reset", int'({busy, done}), 0);
    check(!memReq && !rfWe, "R1", "req/we after reset", int'({memReq, rfWe}), 0);

    for (int r = 0; r < 16; r++) poke(1'b0, r, 8'(8'h11 * r + 3));
    poke(1'b0, 3, 8'hF0);
    poke(1'b0, 4, 8'h1B);
    poke(1'b0, 5, 8'h27);

    // R2 / R13: load index, measure latency
    runOp(OP_SETI, 0, 16'h0300, 1'b0, "R2", 1'b0, lat);
    check(lat == 1, "R13", "load-index latency", lat, 1);
    // R3: add, plain and wrapping
    runOp(OP_ADDI, 3, 16'h0, 1'b0, "R3", 1'b0, lat);
    runOp(OP_SETI, 0, 16'hFFF0, 1'b0, "R2", 1'b0, lat);
    poke(1'b0, 6, 8'h25);
    runOp(OP_ADDI, 6, 16'h0, 1'b0, "R3 wrap", 1'b0, lat);
    // R4 / R5: glyph pointers
    runOp(OP_FONTS, 4, 16'h0, 1'b0, "R4", 1'b0, lat);
    check(lat == 1, "R13", "compact glyph latency", lat, 1);
    runOp(OP_FONTL, 5, 16'h0, 1'b0, "R5", 1'b0, lat);
    check(lat == 1, "R13", "wide glyph latency", lat, 1);
    runOp(OP_FONTS, 3, 16'h0, 1'b0, "R4 high bits", 1'b0, lat);

    // R6: decimal split over digit corners
    runOp(OP_SETI, 0, 16'h0400, 1'b0, "R2", 1'b0, lat);
    poke(1'b0, 7, 8'd0);   runOp(OP_BCD, 7, 16'h0, 1'b0, "R6 zero", 1'b0, lat);
    poke(1'b0, 7, 8'd9);   runOp(OP_BCD, 7, 16'h0, 1'b0, "R6 nine", 1'b0, lat);
    poke(1'b0, 7, 8'd10);  runOp(OP_BCD, 7, 16'h0, 1'b0, "R6 ten", 1'b0, lat);
    poke(1'b0, 7, 8'd99);  runOp(OP_BCD, 7, 16'h0, 1'b0, "R6 99", 1'b0, lat);
    poke(1'b0, 7, 8'd100); runOp(OP_BCD, 7, 16'h0, 1'b0, "R6 100", 1'b0, lat);
    poke(1'b0, 7, 8'd207); runOp(OP_BCD, 7, 16'h0, 1'b0, "R6 207", 1'b0, lat);
    runOp(OP_SETI, 0, 16'hFFFE, 1'b0, "R2", 1'b0, lat);
    poke(1'b0, 7, 8'd255); runOp(OP_BCD, 7, 16'h0, 1'b0, "R6 255 wrap", 1'b0, lat);

    // R12: start while busy is ignored
    runOp(OP_SETI, 0, 16'h0500, 1'b0, "R2", 1'b0, lat);
    poke(1'b0, 7, 8'd198);
    runOp(OP_BCD, 7, 16'h0, 1'b0, "R12 intruded", 1'b1, lat);
    check(expQ.size() == 0 && !busy, "R12", "no extra command",
          expQ.size() + int'(busy), 0);

    // R7 / R8: block store and load with post-increment
    runOp(OP_SETI, 0, 16'h0600, 1'b0, "R2", 1'b0, lat);
    runOp(OP_STORE, 0, 16'h0, 1'b0, "R7 single", 1'b0, lat);
    runOp(OP_STORE, 15, 16'h0, 1'b0, "R7 full", 1'b0, lat);
    for (int k = 0; k < 6; k++) poke(1'b1, 16'h0700 + k, 8'(8'hA0 + k));
    runOp(OP_SETI, 0, 16'h0700, 1'b0, "R2", 1'b0, lat);
    runOp(OP_LOAD, 5, 16'h0, 1'b0, "R8", 1'b0, lat);

    // R9: quirk keeps the index
    runOp(OP_SETI, 0, 16'h0800, 1'b0, "R2", 1'b0, lat);
    runOp(OP_STORE, 4, 16'h0, 1'b1, "R9 store", 1'b0, lat);
    runOp(OP_LOAD, 2, 16'h0, 1'b1, "R9 load", 1'b0, lat);
    runOp(OP_STORE, 1, 16'h0, 1'b0, "R7 after quirk", 1'b0, lat);

    // R10: flag save/restore at address zero
    runOp(OP_FSAVE, 3, 16'h0, 1'b0, "R10 save", 1'b0, lat);
    poke(1'b1, 0, 8'h5A);
    poke(1'b1, 1, 8'hC3);
    runOp(OP_FLOAD, 1, 16'h0, 1'b0, "R10 restore", 1'b0, lat);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule